// File: doc/BRIEF.md
# ADC Conversion Sequencer with Data-Available Tracking

This block is the control side of a touch-panel and sensor converter. Software programs a scan function, a result precision and a filter setting through one control word. The sequencer decides when a conversion set may begin, holds a busy flag for a fixed latency, and on completion marks the channels that the finished function produced as holding fresh data. Each data-available bit is cleared when its result register is read. The converter itself is outside this block; the raw 16-bit channel samples arrive on an input bus, and the sequencer truncates them to the latched precision on read.

A conversion set starts only when three things hold at once: the converter is enabled, it is not busy, and no data-available bit is pending. Touch-coordinate functions also need the panel to be pressed. Single-channel functions turn the converter off once they have delivered data, while scanning functions restart as soon as the host has drained every result. An active-low interrupt pin reports pressure, pending data, or pressure without pending data, depending on a separately written two-bit selector.

There is no streaming interface. Results are read through an offset and a one-cycle read strobe. Read data follows the offset combinationally, and the strobe marks the result as consumed at the next clock edge. Nothing can stall a read, so there is no back-pressure.

Top module: `adc_seq_ctl`

## Requirements
- R1: After reset the converter is disabled, not busy, pin selector is 2, all data-available bits are clear, and `status_word` reads 0x4000 with the panel released. A control write takes effect at the next edge and decodes as follows: bit 15 is host mode (on `host_sel`), bit 14 is an active-low enable, bits 13:10 are the next function, bits 9:8 are the next precision and bits 7:0 are the filter.
- R2: Result reads use the precision latched at start, where code 0 gives 12 bits, 1 gives 8, 2 gives 10 and 3 gives 12. Each result is the raw sample shifted right by 16 minus that width. Offsets 0..3 read samples 0..3, offsets 5..10 read samples 4..9, and any other offset reads 0xFFFF.
- R3: On completion the data-available bits are OR-ed with a mask chosen by the current function code:
  - 1 sets 0x600, 2 sets 0x780, 3 sets 0x400, 4 sets 0x200 and 5 sets 0x180.
  - 6 sets 0x040, 7 sets 0x030, 8 and 9 set 0x010, 10 sets 0x004, 11 sets 0x070 and 12 sets 0x002.
  - 0 and 13..15 set nothing.
- R4: A read strobe at offset 0..3 clears data-available bit 10 minus the offset. A strobe at offset 5..11 clears bit 11 minus the offset.
- R5: Functions 1..5 start only while `pen_down` is high. Functions 6..12 start without regard to pressure. Functions 0 and 13..15 never start.
- R6: For functions 3..5 (while pressed) and 6, 7, 8, 10, 12, the enable clears one cycle after any data-available bit is set, so no further set starts once the data is read.
- R7: A set starts only when enabled, not busy and with all data-available bits clear. At start the next function and next precision are latched, and later control writes do not alter a pending result.
- R8: Busy lasts exactly LAT_CYCLES cycles, and `status_word` bit 14 reads low while busy.
- R9: `pint_n` is driven low for selector 0 when pressed, for selector 1 when any data is pending, and for selector 2 or 3 when pressed with no data pending. It is forced high while disabled.
- R10: A control write that clears the enable while busy ends busy at the next edge and sets no data-available bits.
- R11: `dav_n` is low exactly when at least one data-available bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pen_down | input | 1 | Panel pressed |
| cfg_we | input | 1 | Control word write strobe |
| cfg_data | input | 16 | Control word |
| pin_we | input | 1 | Interrupt selector write strobe |
| pin_sel | input | 2 | Interrupt selector value |
| rd_strobe | input | 1 | Result consumed at this edge |
| rd_offset | input | 4 | Result register offset |
| raw_samples | input | 160 | Ten 16-bit raw samples, sample k at bits 16k+15:16k |
| rd_data | output | 16 | Truncated result for `rd_offset` |
| status_word | output | 16 | {pen, not busy, next function, next precision, filter} |
| dav_bits | output | 11 | Data-available bits |
| host_sel | output | 1 | Host mode bit last written |
| pint_n | output | 1 | Active-low pen/data interrupt |
| dav_n | output | 1 | Active-low any-data-available |

## Verification
The bench targets three kinds of corner case.

- **Mask table and latency.** It runs every function code and counts the busy cycles. A wrong mask-table entry or an off-by-one latency counter shows up directly in `dav_bits` or in the cycle count.
- **Start and stop conditions.** It separates single-shot from scanning functions by watching whether `pint_n` releases one cycle after completion. It checks that draining a single-shot result does not restart, and it checks the pressure gate in both directions. A design that gates the pressure-free scans on pressure would never go busy, and one that forgets self-disable would keep the pin low.
- **Latching and abort.** It rewrites the precision while data is pending and aborts a conversion mid-flight. A design that reads the live precision returns the wrong width, and one that ignores the abort sets data bits that should never appear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DAV_W  = 11;
  localparam int RAW_CH = 10;

  typedef enum logic [3:0] {
    FN_IDLE     = 4'd0,
    FN_XY       = 4'd1,
    FN_XYZ      = 4'd2,
    FN_X        = 4'd3,
    FN_Y        = 4'd4,
    FN_Z        = 4'd5,
    FN_BATA     = 4'd6,
    FN_BATB     = 4'd7,
    FN_AUX      = 4'd8,
    FN_AUXSCAN  = 4'd9,
    FN_TEMPA    = 4'd10,
    FN_PORTSCAN = 4'd11,
    FN_TEMPB    = 4'd12,
    FN_DRV_XX   = 4'd13,
    FN_DRV_YY   = 4'd14,
    FN_DRV_YX   = 4'd15
  } scan_fn_e;

  // Data-available bits produced by a finished conversion set.
  function automatic logic [DAV_W-1:0] done_mask(input scan_fn_e fn);
    case (fn)
      FN_XY:                done_mask = 11'h600;
      FN_XYZ:               done_mask = 11'h780;
      FN_X:                 done_mask = 11'h400;
      FN_Y:                 done_mask = 11'h200;
      FN_Z:                 done_mask = 11'h180;
      FN_BATA:              done_mask = 11'h040;
      FN_BATB:              done_mask = 11'h030;
      FN_AUX, FN_AUXSCAN:   done_mask = 11'h010;
      FN_TEMPA:             done_mask = 11'h004;
      FN_PORTSCAN:          done_mask = 11'h070;
      FN_TEMPB:             done_mask = 11'h002;
      default:              done_mask = '0;
    endcase
  endfunction

  function automatic logic needs_pen(input scan_fn_e fn);
    needs_pen = (fn >= FN_XY) && (fn <= FN_Z);
  endfunction

  function automatic logic can_run(input scan_fn_e fn);
    can_run = (fn != FN_IDLE) && (fn <= FN_TEMPB);
  endfunction

  function automatic logic one_shot(input scan_fn_e fn);
    case (fn)
      FN_X, FN_Y, FN_Z, FN_BATA, FN_BATB, FN_AUX, FN_TEMPA, FN_TEMPB: one_shot = 1'b1;
      default: one_shot = 1'b0;
    endcase
  endfunction

  function automatic int keep_bits(input logic [1:0] prec);
    case (prec)
      2'd1:    keep_bits = 8;
      2'd2:    keep_bits = 10;
      default: keep_bits = 12;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_data,
  input  logic        pin_we,
  input  logic [1:0]  pin_sel,
  input  logic        self_off,
  output logic        en,
  output logic        host_mode,
  output scan_fn_e    next_fn,
  output logic [1:0]  next_prec,
  output logic [7:0]  filter,
  output logic [1:0]  pin_fn
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      host_mode <= 1'b0;
      next_fn   <= FN_IDLE;
      next_prec <= 2'd0;
      filter    <= 8'd0;
      pin_fn    <= 2'd2;
    end else begin
      if (cfg_we) begin
        host_mode <= cfg_data[15];
        en        <= ~cfg_data[14];
        next_fn   <= scan_fn_e'(cfg_data[13:10]);
        next_prec <= cfg_data[9:8];
        filter    <= cfg_data[7:0];
      end else if (self_off) begin
        en <= 1'b0;
      end
      if (pin_we) pin_fn <= pin_sel;
    end
  end

  // R1: an enabling write always leaves the converter enabled
  a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_data[14] |=> en);

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int LAT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(LAT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LAT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0) && !abort;

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort |=> busy);

  a_r10_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

// File: rtl/adc_seq_dav.sv
module adc_seq_dav
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  scan_fn_e         cur_fn,
  input  logic             rd_strobe,
  input  logic [3:0]       rd_offset,
  output logic [DAV_W-1:0] dav
);

  logic [DAV_W-1:0] clr;

  always_comb begin
    clr = '0;
    if (rd_strobe) begin
      if (rd_offset <= 4'd3)
        clr[4'd10 - rd_offset] = 1'b1;
      else if (rd_offset >= 4'd5 && rd_offset <= 4'd11)
        clr[4'd11 - rd_offset] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dav <= '0;
    else        dav <= (dav & ~clr) | (done ? done_mask(cur_fn) : '0);
  end

  // R3: fresh data bits appear only on a completion
  a_r3_bits_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dav & ~$past(dav))) |-> $past(done));

  a_r4_read_x_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && rd_offset == 4'd0 && !done |=> !dav[10]);

endmodule

// File: rtl/adc_seq_rdmux.sv
module adc_seq_rdmux
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [RAW_CH*SAMPLE_W-1:0] raw_samples,
  input  logic [1:0]                 prec,
  input  logic [3:0]                 rd_offset,
  output logic [SAMPLE_W-1:0]        rd_data
);

  logic [SAMPLE_W-1:0] cut [RAW_CH];

  for (genvar g = 0; g < RAW_CH; g++) begin : g_cut
    assign cut[g] = raw_samples[g*SAMPLE_W +: SAMPLE_W] >> (SAMPLE_W - keep_bits(prec));
  end

  always_comb begin
    rd_data = '1;
    if (rd_offset <= 4'd3)
      rd_data = cut[rd_offset];
    else if (rd_offset >= 4'd5 && rd_offset <= 4'd10)
      rd_data = cut[rd_offset - 4'd1];
  end

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int LAT_CYCLES = 32,
  parameter int SAMPLE_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pen_down,
  input  logic                       cfg_we,
  input  logic [15:0]                cfg_data,
  input  logic                       pin_we,
  input  logic [1:0]                 pin_sel,
  input  logic                       rd_strobe,
  input  logic [3:0]                 rd_offset,
  input  logic [RAW_CH*SAMPLE_W-1:0] raw_samples,
  output logic [SAMPLE_W-1:0]        rd_data,
  output logic [15:0]                status_word,
  output logic [DAV_W-1:0]           dav_bits,
  output logic                       host_sel,
  output logic                       pint_n,
  output logic                       dav_n
);

  logic       en, busy, done, start, self_off, abort, pen_ok, pin_src, any_dav;
  scan_fn_e   next_fn, cur_fn;
  logic [1:0] next_prec, cur_prec, pin_fn;
  logic [7:0] filter;

  assign any_dav  = |dav_bits;
  assign pen_ok   = !needs_pen(next_fn) || pen_down;
  assign start    = en && !busy && !any_dav && can_run(next_fn) && pen_ok && !cfg_we;
  assign self_off = one_shot(next_fn) && any_dav && pen_ok;
  assign abort    = cfg_we && cfg_data[14];

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .pin_we(pin_we), .pin_sel(pin_sel), .self_off(self_off),
    .en(en), .host_mode(host_sel), .next_fn(next_fn), .next_prec(next_prec),
    .filter(filter), .pin_fn(pin_fn)
  );

  adc_seq_timer #(.LAT_CYCLES(LAT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fn   <= FN_IDLE;
      cur_prec <= 2'd0;
    end else if (start) begin
      cur_fn   <= next_fn;
      cur_prec <= next_prec;
    end
  end

  adc_seq_dav u_dav (
    .clk(clk), .rst_n(rst_n), .done(done), .cur_fn(cur_fn),
    .rd_strobe(rd_strobe), .rd_offset(rd_offset), .dav(dav_bits)
  );

  adc_seq_rdmux #(.SAMPLE_W(SAMPLE_W)) u_rd (
    .raw_samples(raw_samples), .prec(cur_prec), .rd_offset(rd_offset),
    .rd_data(rd_data)
  );

  always_comb begin
    case (pin_fn)
      2'd0:    pin_src = pen_down;
      2'd1:    pin_src = any_dav;
      default: pin_src = pen_down && !any_dav;
    endcase
  end

  assign pint_n      = !(en && pin_src);
  assign dav_n       = !any_dav;
  assign status_word = {pen_down, !busy, next_fn, next_prec, filter};

  a_r7_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en) && !$past(any_dav));

  a_r9_pin_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pint_n);

  a_r5_no_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !can_run(next_fn) && !busy |=> !busy);

endmodule

// File: tb/sim_adc_seq_ctl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctl;

  localparam int LAT = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pen_down = 1'b0, cfg_we = 1'b0, pin_we = 1'b0, rd_strobe = 1'b0;
  logic [15:0]  cfg_data = '0;
  logic [1:0]   pin_sel = '0;
  logic [3:0]   rd_offset = '0;
  logic [159:0] raw_samples;
  logic [15:0]  rd_data, status_word;
  logic [10:0]  dav_bits;
  logic         host_sel, pint_n, dav_n;

  int total = 0, failed = 0;

  always #4 clk = ~clk;

  adc_seq_ctl #(.LAT_CYCLES(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pen_down(pen_down), .cfg_we(cfg_we),
    .cfg_data(cfg_data), .pin_we(pin_we), .pin_sel(pin_sel),
    .rd_strobe(rd_strobe), .rd_offset(rd_offset), .raw_samples(raw_samples),
    .rd_data(rd_data), .status_word(status_word), .dav_bits(dav_bits),
    .host_sel(host_sel), .pint_n(pint_n), .dav_n(dav_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pen_down = 1'b0; cfg_we = 1'b0; pin_we = 1'b0; rd_strobe = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    cfg_data = v; cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_pin(input logic [1:0] v);
    pin_sel = v; pin_we = 1'b1;
    step(1);
    pin_we = 1'b0;
  endtask

  task automatic rd_clear(input logic [3:0] off);
    rd_offset = off; rd_strobe = 1'b1;
    step(1);
    rd_strobe = 1'b0;
  endtask

  // Enabled control word: function and precision, filter zero
  function automatic logic [15:0] cw(input int fn, input int prec);
    return 16'((fn << 10) | (prec << 8));
  endfunction

  // Waits while busy; returns busy cycle count seen from the first busy sample
  task automatic wait_idle(output int n);
    n = 0;
    while (status_word[14] == 1'b0 && n < LAT + 10) begin
      step(1);
      n++;
    end
  endtask

  function automatic logic [10:0] exp_mask(input int fn);
    case (fn)
      1: return 11'h600;  2: return 11'h780;  3: return 11'h400;
      4: return 11'h200;  5: return 11'h180;  6: return 11'h040;
      7: return 11'h030;  8: return 11'h010;  9: return 11'h010;
      10: return 11'h004; 11: return 11'h070; 12: return 11'h002;
      default: return 11'h000;
    endcase
  endfunction

  function automatic logic [15:0] sample(input int k);
    return 16'hABCD ^ 16'(k * 16'h1111);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 reset status", status_word, 16'h4000);
    chk("R1 reset dav bits", dav_bits, 11'h000);
    chk("R11 reset dav_n", dav_n, 1'b1);
    chk("R9 reset pin", pint_n, 1'b1);
  endtask

  task automatic t_decode();
    do_reset();
    wr_cfg(16'hF75A);
    chk("R1 decode status", status_word, 16'h775A);
    chk("R1 host mode", host_sel, 1'b1);
    step(3);
    chk("R1 disabled no start", status_word[14], 1'b1);
  endtask

  task automatic t_modes();
    int n;
    for (int fn = 0; fn < 16; fn++) begin
      do_reset();
      pen_down = 1'b1;
      wr_cfg(cw(fn, 0));
      step(1);
      if (fn == 0 || fn >= 13) begin
        step(3);
        chk($sformatf("R5 fn%0d never busy", fn), status_word[14], 1'b1);
        chk($sformatf("R3 fn%0d no bits", fn), dav_bits, 11'h000);
      end else begin
        chk($sformatf("R8 fn%0d busy", fn), status_word[14], 1'b0);
        chk($sformatf("R8 fn%0d dav idle while busy", fn), dav_bits, 11'h000);
        wait_idle(n);
        chk($sformatf("R8 fn%0d latency", fn), n, LAT);
        chk($sformatf("R3 fn%0d mask", fn), dav_bits, exp_mask(fn));
        chk($sformatf("R11 fn%0d dav_n", fn), dav_n, 1'b0);
      end
    end
  endtask

  task automatic t_pen_gate();
    do_reset();
    wr_cfg(cw(3, 0));
    step(4);
    chk("R5 X waits for pen", status_word[14], 1'b1);
    pen_down = 1'b1;
    step(1);
    chk("R5 X starts on pen", status_word[14], 1'b0);
    do_reset();
    wr_cfg(cw(11, 0));
    step(1);
    chk("R5 port scan no pen", status_word[14], 1'b0);
    do_reset();
    wr_cfg(cw(9, 0));
    step(1);
    chk("R5 aux scan no pen", status_word[14], 1'b0);
  endtask

  task automatic t_trunc();
    int n;
    int res [4] = '{12, 8, 10, 12};
    for (int p = 0; p < 4; p++) begin
      do_reset();
      wr_cfg(cw(9, p));
      step(1);
      wait_idle(n);
      rd_offset = 4'd7;
      #1;
      chk($sformatf("R2 prec%0d offset7", p), rd_data, sample(6) >> (16 - res[p]));
      rd_offset = 4'd2;
      #1;
      chk($sformatf("R2 prec%0d offset2", p), rd_data, sample(2) >> (16 - res[p]));
    end
    rd_offset = 4'd4;
    #1;
    chk("R2 offset4 blank", rd_data, 16'hFFFF);
    rd_offset = 4'd11;
    #1;
    chk("R2 offset11 blank", rd_data, 16'hFFFF);
    // data pending: a new precision must not change the result width
    wr_cfg(cw(9, 1));
    step(2);
    rd_offset = 4'd7;
    #1;
    chk("R7 precision latched", rd_data, sample(6) >> 4);
    chk("R7 no start while pending", status_word[14], 1'b1);
  endtask

  task automatic t_read_clear();
    int n;
    do_reset();
    pen_down = 1'b1;
    wr_cfg(cw(2, 0));
    step(1);
    wait_idle(n);
    rd_clear(4'd0);
    chk("R4 clear X", dav_bits, 11'h380);
    rd_clear(4'd1);
    chk("R4 clear Y", dav_bits, 11'h180);
    rd_clear(4'd2);
    chk("R4 clear Z1", dav_bits, 11'h080);
    chk("R11 dav_n with one bit", dav_n, 1'b0);
    rd_clear(4'd3);
    chk("R4 clear Z2", dav_bits, 11'h000);
    chk("R11 dav_n empty", dav_n, 1'b1);
    do_reset();
    wr_cfg(cw(11, 0));
    step(1);
    wait_idle(n);
    rd_clear(4'd5);
    chk("R4 clear off5", dav_bits, 11'h030);
    rd_clear(4'd6);
    chk("R4 clear off6", dav_bits, 11'h010);
    rd_clear(4'd7);
    chk("R4 clear off7", dav_bits, 11'h000);
  endtask

  task automatic t_self_disable();
    int n;
    do_reset();
    wr_pin(2'd1);
    wr_cfg(cw(6, 0));
    step(1);
    wait_idle(n);
    chk("R9 pin on data", pint_n, 1'b0);
    step(1);
    chk("R6 one-shot disables", pint_n, 1'b1);
    rd_clear(4'd5);
    step(3);
    chk("R6 no restart", status_word[14], 1'b1);
    chk("R6 no new data", dav_bits, 11'h000);
    do_reset();
    wr_pin(2'd1);
    wr_cfg(cw(9, 0));
    step(1);
    wait_idle(n);
    step(2);
    chk("R6 scan stays enabled", pint_n, 1'b0);
  endtask

  task automatic t_pin();
    int n;
    do_reset();
    wr_pin(2'd0);
    wr_cfg(cw(0, 0));
    pen_down = 1'b1;
    #1;
    chk("R9 sel0 pressed", pint_n, 1'b0);
    pen_down = 1'b0;
    #1;
    chk("R9 sel0 released", pint_n, 1'b1);
    wr_pin(2'd2);
    pen_down = 1'b1;
    #1;
    chk("R9 sel2 pressed idle", pint_n, 1'b0);
    wr_cfg(cw(1, 0));
    step(1);
    wait_idle(n);
    chk("R9 sel2 data pending", pint_n, 1'b1);
    wr_pin(2'd1);
    chk("R9 sel1 data pending", pint_n, 1'b0);
    wr_pin(2'd0);
    wr_cfg(16'h4000);
    chk("R9 disabled forces high", pint_n, 1'b1);
  endtask

  task automatic t_abort();
    do_reset();
    wr_cfg(cw(9, 0));
    step(4);
    chk("R10 busy before abort", status_word[14], 1'b0);
    wr_cfg(16'h4000 | cw(9, 0));
    chk("R10 abort ends busy", status_word[14], 1'b1);
    step(LAT + 4);
    chk("R10 no data after abort", dav_bits, 11'h000);
  endtask

  initial begin
    for (int k = 0; k < 10; k++) raw_samples[k*16 +: 16] = sample(k);
    t_reset();
    t_decode();
    t_modes();
    t_pen_gate();
    t_trunc();
    t_read_clear();
    t_self_disable();
    t_pin();
    t_abort();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule